// File: doc/BRIEF.md
# DSP Local Memory Bank with Boot Mapping

This block holds the local memory of one 24-bit DSP core. It serves three independent address spaces, X data, Y data and program, and each space has its own 16-bit address, read strobe, write strobe and 24-bit data. Each data space holds a single-port RAM at the bottom of the space and a fixed-content ROM above it. The program space holds a program RAM whose depth is set per core instance, and a bootstrap ROM.

A one-bit operating-mode register sits at a fixed X-space address. It is set by the bench reset and by the per-core reset control, and boot code clears it by writing to it. While the bit is set, instruction reads from the bottom of program space come from the bootstrap ROM. Once it is clear, they come from the program RAM. Program RAM is written only when the write carries the move-program-memory qualifier. Every read returns its word one clock after the strobe, whichever array it hits.

Top module: `dsp_mem_bank`

## Requirements
- R1: The X and Y RAMs each hold 256 words at addresses 0x0000–0x00FF of their own space. A word written at an address is returned by a later read of that address in the same space, and a write to one space leaves the other space unchanged.
- R2: The X and Y ROMs answer at 0x0100–0x01FF. Entry i holds (SEED + i × 0x010101) mod 2^24, where SEED is 0x100000 for X and 0x200000 for Y. Writes to these addresses are ignored.
- R3: The read data for a read strobe in cycle n appears on the data output in cycle n+1. In a cycle that follows a cycle with no read strobe, the output is zero.
- R4: A read of an address that maps to no array or register returns zero. A write to such an address changes no stored word, and the RAM does not alias above its range (a write at 0x1005 leaves RAM word 0x0005 unchanged).
- R5: The mode register sits at X address 0x0200. A write sets it to write-data bit 0. A read returns the bit in position 0 with all other bits zero, and the bit is also driven on `boot_mode`.
- R6: Both the bench reset (`rst_n` low) and a one-cycle `core_rst` pulse set the mode bit to 1. `core_rst` takes priority over a mode write in the same cycle.
- R7: While the mode bit is 1, program reads of 0x0000–0x007F return bootstrap ROM entry i = (0x300000 + i × 0x010101) mod 2^24. While the bit is 0, the same addresses return program RAM.
- R8: Program RAM occupies program addresses 0 up to PRAM_DEPTH−1 (768 by default). It is readable above the boot window in either mode, and program reads at or above PRAM_DEPTH return zero.
- R9: A program write changes program RAM only when `p_movem` is 1 in the same cycle. Such a write reaches the program RAM even inside the boot window while the mode bit is 1.
- R10: A read and a write to the same RAM address in the same cycle return the word stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_rst | input | 1 | Per-core reset pulse, sets the mode bit |
| x_addr | input | 16 | X-space address |
| x_rd | input | 1 | X read strobe |
| x_wr | input | 1 | X write strobe |
| x_wdata | input | 24 | X write data |
| x_rdata | output | 24 | X read data, one cycle after the strobe |
| y_addr | input | 16 | Y-space address |
| y_rd | input | 1 | Y read strobe |
| y_wr | input | 1 | Y write strobe |
| y_wdata | input | 24 | Y write data |
| y_rdata | output | 24 | Y read data, one cycle after the strobe |
| p_addr | input | 16 | Program-space address |
| p_rd | input | 1 | Program read (fetch) strobe |
| p_wr | input | 1 | Program write strobe |
| p_movem | input | 1 | Move-program-memory qualifier for program writes |
| p_wdata | input | 24 | Program write data |
| p_rdata | output | 24 | Program read data, one cycle after the strobe |
| boot_mode | output | 1 | Mode bit: 1 = boot fetch, 0 = normal fetch |

## Verification
A wrong mode bit shows up on the next fetch from the boot window, which returns a program RAM word in place of the computed boot-ROM word or the reverse. The `boot_mode` pin shows the error one cycle after the write or reset that caused it. A wrong source select or decode puts a wrong word, or a nonzero word, on the data bus exactly one cycle after the offending strobe. A lost or unqualified write stays hidden until that address is read back. The bench therefore follows every write it cares about with a read of the same address.

// File: rtl/dsp_mem_pkg.sv
package dsp_mem_pkg;

   localparam int WORD_W = 24;
   localparam int ADDR_W = 16;

   typedef logic [WORD_W-1:0] word_t;
   typedef logic [ADDR_W-1:0] addr_t;

   // which array drove the registered read path
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_RAM  = 2'd1,
      SRC_ROM  = 2'd2,
      SRC_AUX  = 2'd3
   } src_sel_t;

   // fixed ROM content rule: entry i = seed + i * 0x010101 (mod 2^24)
   function automatic word_t rom_word(input word_t seed, input int unsigned idx);
      word_t k;
      k = word_t'(idx);
      return seed + k * word_t'(24'h010101);
   endfunction

endpackage

// File: rtl/mem_ram_sp.sv
module mem_ram_sp
   import dsp_mem_pkg::*;
#(
   parameter int DEPTH = 256
)(
   input  logic                     clk,
   input  logic                     we,
   input  logic                     re,
   input  logic [$clog2(DEPTH)-1:0] idx,
   input  word_t                    wdata,
   output word_t                    rdata
);

   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("mem_ram_sp: DEPTH must be at least 2");
      end
   endgenerate

   word_t mem [DEPTH];

   // read-before-write: the read port sees the word stored before this edge
   always_ff @(posedge clk) begin
      if (we) begin
         mem[idx] <= wdata;
      end
      if (re) begin
         rdata <= mem[idx];
      end
   end

   logic unused_aw;
   assign unused_aw = (AW == 0);

endmodule

// File: rtl/mem_rom_calc.sv
module mem_rom_calc
   import dsp_mem_pkg::*;
#(
   parameter int    DEPTH = 256,
   parameter word_t SEED  = 24'h100000
)(
   input  logic                     clk,
   input  logic                     re,
   input  logic [$clog2(DEPTH)-1:0] idx,
   output word_t                    rdata
);

   localparam int AW = $clog2(DEPTH);

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("mem_rom_calc: DEPTH must be a power of two");
      end
   endgenerate

   word_t tbl [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_fill
         assign tbl[i] = rom_word(SEED, i);
      end
   endgenerate

   // output register aligns ROM latency with the RAM read port
   always_ff @(posedge clk) begin
      if (re) begin
         rdata <= tbl[idx];
      end
   end

endmodule

// File: rtl/mem_mode_reg.sv
module mem_mode_reg
   import dsp_mem_pkg::*;
#(
   parameter addr_t MODE_ADDR = 16'h0200
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  core_rst,
   input  addr_t addr,
   input  logic  wr,
   input  logic  wbit,
   output logic  hit,
   output word_t rdata,
   output logic  boot_mode
);

   logic mode_q;

   assign hit = (addr == MODE_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b1;
      end else if (core_rst) begin
         mode_q <= 1'b1;
      end else if (wr && hit) begin
         mode_q <= wbit;
      end
   end

   assign boot_mode = mode_q;
   assign rdata     = {{(WORD_W-1){1'b0}}, mode_q};

   a_r6_core_rst_sets: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst |=> boot_mode);

   a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_rst && wr && (addr == MODE_ADDR) && !wbit) |=> !boot_mode);

   a_r5_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_rst && !(wr && (addr == MODE_ADDR))) |=> $stable(boot_mode));

endmodule

// File: rtl/mem_data_space.sv
module mem_data_space
   import dsp_mem_pkg::*;
#(
   parameter int    RAM_DEPTH = 256,
   parameter addr_t ROM_BASE  = 16'h0100,
   parameter int    ROM_DEPTH = 256,
   parameter word_t ROM_SEED  = 24'h100000
)(
   input  logic  clk,
   input  logic  rst_n,
   input  addr_t addr,
   input  logic  rd,
   input  logic  wr,
   input  word_t wdata,
   input  logic  aux_sel,
   input  word_t aux_rdata,
   output word_t rdata
);

   localparam int RAM_AW = $clog2(RAM_DEPTH);
   localparam int ROM_AW = $clog2(ROM_DEPTH);
   localparam logic [ADDR_W:0] RAM_END = (ADDR_W+1)'(RAM_DEPTH);
   localparam logic [ADDR_W:0] ROM_LO  = {1'b0, ROM_BASE};
   localparam logic [ADDR_W:0] ROM_HI  = ROM_LO + (ADDR_W+1)'(ROM_DEPTH);

   generate
      if ((1 << RAM_AW) != RAM_DEPTH) begin : g_bad_ram
         $error("mem_data_space: RAM_DEPTH must be a power of two");
      end
      if (RAM_END > ROM_LO) begin : g_overlap
         $error("mem_data_space: RAM and ROM ranges overlap");
      end
      if ((int'(ROM_BASE) % ROM_DEPTH) != 0) begin : g_align
         $error("mem_data_space: ROM_BASE must be aligned to ROM_DEPTH");
      end
   endgenerate

   logic     ram_hit, rom_hit;
   src_sel_t sel_q;
   word_t    ram_q, rom_q, aux_q;

   assign ram_hit = ({1'b0, addr} < RAM_END);
   assign rom_hit = ({1'b0, addr} >= ROM_LO) && ({1'b0, addr} < ROM_HI);

   mem_ram_sp #(.DEPTH(RAM_DEPTH)) u_ram (
      .clk   (clk),
      .we    (wr && ram_hit),
      .re    (rd && ram_hit),
      .idx   (addr[RAM_AW-1:0]),
      .wdata (wdata),
      .rdata (ram_q)
   );

   mem_rom_calc #(.DEPTH(ROM_DEPTH), .SEED(ROM_SEED)) u_rom (
      .clk   (clk),
      .re    (rd && rom_hit),
      .idx   (addr[ROM_AW-1:0]),
      .rdata (rom_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= SRC_NONE;
      end else if (!rd) begin
         sel_q <= SRC_NONE;
      end else if (ram_hit) begin
         sel_q <= SRC_RAM;
      end else if (rom_hit) begin
         sel_q <= SRC_ROM;
      end else if (aux_sel) begin
         sel_q <= SRC_AUX;
      end else begin
         sel_q <= SRC_NONE;
      end
   end

   always_ff @(posedge clk) begin
      if (rd && aux_sel) begin
         aux_q <= aux_rdata;
      end
   end

   always_comb begin
      unique case (sel_q)
         SRC_RAM: rdata = ram_q;
         SRC_ROM: rdata = rom_q;
         SRC_AUX: rdata = aux_q;
         default: rdata = '0;
      endcase
   end

   a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> (rdata == '0));

   a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !aux_sel && (32'(addr) >= RAM_DEPTH) &&
       ((32'(addr) < 32'(ROM_BASE)) || (32'(addr) >= 32'(ROM_BASE) + ROM_DEPTH)))
      |=> (rdata == '0));

   a_r1_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr) && rd && (addr == $past(addr)) && (32'(addr) < RAM_DEPTH))
      |=> (rdata == $past(wdata, 2)));

endmodule

// File: rtl/mem_prog_space.sv
module mem_prog_space
   import dsp_mem_pkg::*;
#(
   parameter int    PRAM_DEPTH = 768,
   parameter int    BOOT_DEPTH = 128,
   parameter word_t BOOT_SEED  = 24'h300000
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  boot_mode,
   input  addr_t addr,
   input  logic  rd,
   input  logic  wr,
   input  logic  movem,
   input  word_t wdata,
   output word_t rdata
);

   localparam int PRAM_AW = $clog2(PRAM_DEPTH);
   localparam int BOOT_AW = $clog2(BOOT_DEPTH);
   localparam logic [ADDR_W:0] PRAM_END = (ADDR_W+1)'(PRAM_DEPTH);
   localparam logic [ADDR_W:0] BOOT_END = (ADDR_W+1)'(BOOT_DEPTH);

   generate
      if (PRAM_DEPTH < BOOT_DEPTH) begin : g_small_pram
         $error("mem_prog_space: PRAM_DEPTH must cover the boot window");
      end
      if (PRAM_DEPTH > (1 << ADDR_W)) begin : g_big_pram
         $error("mem_prog_space: PRAM_DEPTH exceeds the address space");
      end
   endgenerate

   logic     pram_hit, boot_hit, pram_re, boot_re;
   src_sel_t sel_q;
   word_t    pram_q, boot_q;

   assign pram_hit = ({1'b0, addr} < PRAM_END);
   assign boot_hit = boot_mode && ({1'b0, addr} < BOOT_END);
   assign boot_re  = rd && boot_hit;
   assign pram_re  = rd && pram_hit && !boot_hit;

   mem_ram_sp #(.DEPTH(PRAM_DEPTH)) u_pram (
      .clk   (clk),
      .we    (wr && movem && pram_hit),
      .re    (pram_re),
      .idx   (addr[PRAM_AW-1:0]),
      .wdata (wdata),
      .rdata (pram_q)
   );

   mem_rom_calc #(.DEPTH(BOOT_DEPTH), .SEED(BOOT_SEED)) u_boot (
      .clk   (clk),
      .re    (boot_re),
      .idx   (addr[BOOT_AW-1:0]),
      .rdata (boot_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= SRC_NONE;
      end else if (boot_re) begin
         sel_q <= SRC_ROM;
      end else if (pram_re) begin
         sel_q <= SRC_RAM;
      end else begin
         sel_q <= SRC_NONE;
      end
   end

   always_comb begin
      unique case (sel_q)
         SRC_RAM: rdata = pram_q;
         SRC_ROM: rdata = boot_q;
         default: rdata = '0;
      endcase
   end

   a_r7_single_source: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({boot_re, pram_re}));

   a_r3_fetch_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> (rdata == '0));

   a_r8_beyond_pram_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (32'(addr) >= PRAM_DEPTH)) |=> (rdata == '0));

endmodule

// File: rtl/dsp_mem_bank.sv
module dsp_mem_bank
   import dsp_mem_pkg::*;
#(
   parameter int    XRAM_DEPTH = 256,
   parameter int    YRAM_DEPTH = 256,
   parameter int    XROM_DEPTH = 256,
   parameter int    YROM_DEPTH = 256,
   parameter addr_t ROM_BASE   = 16'h0100,
   parameter int    PRAM_DEPTH = 768,
   parameter int    BOOT_DEPTH = 128,
   parameter addr_t MODE_ADDR  = 16'h0200,
   parameter word_t XROM_SEED  = 24'h100000,
   parameter word_t YROM_SEED  = 24'h200000,
   parameter word_t BOOT_SEED  = 24'h300000
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        core_rst,
   input  logic [15:0] x_addr,
   input  logic        x_rd,
   input  logic        x_wr,
   input  logic [23:0] x_wdata,
   output logic [23:0] x_rdata,
   input  logic [15:0] y_addr,
   input  logic        y_rd,
   input  logic        y_wr,
   input  logic [23:0] y_wdata,
   output logic [23:0] y_rdata,
   input  logic [15:0] p_addr,
   input  logic        p_rd,
   input  logic        p_wr,
   input  logic        p_movem,
   input  logic [23:0] p_wdata,
   output logic [23:0] p_rdata,
   output logic        boot_mode
);

   generate
      if ((int'(MODE_ADDR) < XRAM_DEPTH) ||
          ((int'(MODE_ADDR) >= int'(ROM_BASE)) &&
           (int'(MODE_ADDR) < int'(ROM_BASE) + XROM_DEPTH))) begin : g_mode_clash
         $error("dsp_mem_bank: MODE_ADDR falls inside an X array");
      end
   endgenerate

   logic  mode_hit;
   word_t mode_rdata;

   mem_mode_reg #(.MODE_ADDR(MODE_ADDR)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .core_rst  (core_rst),
      .addr      (x_addr),
      .wr        (x_wr),
      .wbit      (x_wdata[0]),
      .hit       (mode_hit),
      .rdata     (mode_rdata),
      .boot_mode (boot_mode)
   );

   mem_data_space #(
      .RAM_DEPTH (XRAM_DEPTH),
      .ROM_BASE  (ROM_BASE),
      .ROM_DEPTH (XROM_DEPTH),
      .ROM_SEED  (XROM_SEED)
   ) u_xspace (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (x_addr),
      .rd        (x_rd),
      .wr        (x_wr),
      .wdata     (x_wdata),
      .aux_sel   (mode_hit),
      .aux_rdata (mode_rdata),
      .rdata     (x_rdata)
   );

   mem_data_space #(
      .RAM_DEPTH (YRAM_DEPTH),
      .ROM_BASE  (ROM_BASE),
      .ROM_DEPTH (YROM_DEPTH),
      .ROM_SEED  (YROM_SEED)
   ) u_yspace (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (y_addr),
      .rd        (y_rd),
      .wr        (y_wr),
      .wdata     (y_wdata),
      .aux_sel   (1'b0),
      .aux_rdata ('0),
      .rdata     (y_rdata)
   );

   mem_prog_space #(
      .PRAM_DEPTH (PRAM_DEPTH),
      .BOOT_DEPTH (BOOT_DEPTH),
      .BOOT_SEED  (BOOT_SEED)
   ) u_pspace (
      .clk       (clk),
      .rst_n     (rst_n),
      .boot_mode (boot_mode),
      .addr      (p_addr),
      .rd        (p_rd),
      .wr        (p_wr),
      .movem     (p_movem),
      .wdata     (p_wdata),
      .rdata     (p_rdata)
   );

endmodule

// File: tb/dsp_mem_bank_tb.sv
module dsp_mem_bank_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_rst = 1'b0;
   logic [15:0] x_addr = '0, y_addr = '0, p_addr = '0;
   logic        x_rd = 1'b0, x_wr = 1'b0, y_rd = 1'b0, y_wr = 1'b0;
   logic        p_rd = 1'b0, p_wr = 1'b0, p_movem = 1'b0;
   logic [23:0] x_wdata = '0, y_wdata = '0, p_wdata = '0;
   logic [23:0] x_rdata, y_rdata, p_rdata;
   logic        boot_mode;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [23:0] xq[$], yq[$], pq[$];
   string       xr[$], yr[$], pr[$];

   always #5 clk = ~clk;

   dsp_mem_bank dut_i (
      .clk(clk), .rst_n(rst_n), .core_rst(core_rst),
      .x_addr(x_addr), .x_rd(x_rd), .x_wr(x_wr), .x_wdata(x_wdata), .x_rdata(x_rdata),
      .y_addr(y_addr), .y_rd(y_rd), .y_wr(y_wr), .y_wdata(y_wdata), .y_rdata(y_rdata),
      .p_addr(p_addr), .p_rd(p_rd), .p_wr(p_wr), .p_movem(p_movem), .p_wdata(p_wdata),
      .p_rdata(p_rdata), .boot_mode(boot_mode)
   );

   function automatic logic [23:0] romw(input logic [23:0] seed, input int i);
      return seed + 24'(i) * 24'h010101;
   endfunction

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %06h expected %06h", req, act, exp);
      end
   endtask

   task automatic clear_all();
      x_rd = 0; x_wr = 0; y_rd = 0; y_wr = 0;
      p_rd = 0; p_wr = 0; p_movem = 0; core_rst = 0;
   endtask

   task automatic xop(input logic [15:0] a, input logic rd, input logic wr,
                      input logic [23:0] d, input logic [23:0] e, input string r);
      @(negedge clk); clear_all();
      x_addr = a; x_rd = rd; x_wr = wr; x_wdata = d;
      if (rd) begin xq.push_back(e); xr.push_back(r); end
   endtask

   task automatic yop(input logic [15:0] a, input logic rd, input logic wr,
                      input logic [23:0] d, input logic [23:0] e, input string r);
      @(negedge clk); clear_all();
      y_addr = a; y_rd = rd; y_wr = wr; y_wdata = d;
      if (rd) begin yq.push_back(e); yr.push_back(r); end
   endtask

   task automatic pop(input logic [15:0] a, input logic rd, input logic wr, input logic mv,
                      input logic [23:0] d, input logic [23:0] e, input string r);
      @(negedge clk); clear_all();
      p_addr = a; p_rd = rd; p_wr = wr; p_movem = mv; p_wdata = d;
      if (rd) begin pq.push_back(e); pr.push_back(r); end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); clear_all();
      end
   endtask

   task automatic mode_is(input logic exp, input string r);
      @(posedge clk); #2;
      chk(r, {23'b0, boot_mode}, {23'b0, exp});
   endtask

   // monitor: pops one expected word per read strobe, else expects zero (R3)
   initial begin
      logic xs, ys, ps;
      @(posedge rst_n);
      forever begin
         @(posedge clk);
         xs = x_rd; ys = y_rd; ps = p_rd;
         #2;
         if (xs) begin
            if (xq.size() == 0) chk("X queue empty", x_rdata, 24'hxxxxxx);
            else chk(xr.pop_front(), x_rdata, xq.pop_front());
         end else chk("R3 X idle", x_rdata, 24'h0);
         if (ys) begin
            if (yq.size() == 0) chk("Y queue empty", y_rdata, 24'hxxxxxx);
            else chk(yr.pop_front(), y_rdata, yq.pop_front());
         end else chk("R3 Y idle", y_rdata, 24'h0);
         if (ps) begin
            if (pq.size() == 0) chk("P queue empty", p_rdata, 24'hxxxxxx);
            else chk(pr.pop_front(), p_rdata, pq.pop_front());
         end else chk("R3 P idle", p_rdata, 24'h0);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1; chk("R6 reset sets mode", {23'b0, boot_mode}, 24'h1);
      @(negedge clk); rst_n = 1'b1;
      idle(2);

      // R1 RAM write/read, spaces independent
      xop(16'h0005, 0, 1, 24'hABCDEF, 0, "");
      xop(16'h00FF, 0, 1, 24'h123456, 0, "");
      yop(16'h0005, 0, 1, 24'h654321, 0, "");
      xop(16'h0005, 1, 0, 0, 24'hABCDEF, "R1 X ram 0x05");
      xop(16'h00FF, 1, 0, 0, 24'h123456, "R1 X ram 0xFF");
      yop(16'h0005, 1, 0, 0, 24'h654321, "R1 Y ram 0x05");

      // R2 ROM content and write ignore
      xop(16'h0100, 1, 0, 0, romw(24'h100000, 0), "R2 X rom 0");
      xop(16'h01FF, 1, 0, 0, romw(24'h100000, 255), "R2 X rom 255");
      yop(16'h0180, 1, 0, 0, romw(24'h200000, 128), "R2 Y rom 128");
      xop(16'h0100, 0, 1, 24'h0F0F0F, 0, "");
      xop(16'h0100, 1, 0, 0, romw(24'h100000, 0), "R2 X rom write ignored");

      // R4 unmapped
      xop(16'h1005, 0, 1, 24'h777777, 0, "");
      xop(16'h0005, 1, 0, 0, 24'hABCDEF, "R4 no alias above RAM");
      xop(16'h0300, 1, 0, 0, 24'h0, "R4 X unmapped read");
      yop(16'hFFFF, 1, 0, 0, 24'h0, "R4 Y unmapped read");
      yop(16'h0200, 1, 0, 0, 24'h0, "R4 Y has no mode reg");

      // R10 same-cycle read and write
      xop(16'h0010, 0, 1, 24'h000111, 0, "");
      xop(16'h0010, 1, 1, 24'h000222, 24'h000111, "R10 read old word");
      xop(16'h0010, 1, 0, 0, 24'h000222, "R10 new word stored");

      // R5 mode readback, R7 boot fetch, R9 qualified writes, R8 range
      xop(16'h0200, 1, 0, 0, 24'h000001, "R5 mode read 1");
      pop(16'h0000, 1, 0, 0, 0, romw(24'h300000, 0), "R7 boot rom 0");
      pop(16'h007F, 1, 0, 0, 0, romw(24'h300000, 127), "R7 boot rom 127");
      pop(16'h0000, 0, 1, 1, 24'h0A0A0A, 0, "");
      pop(16'h0000, 1, 0, 0, 0, romw(24'h300000, 0), "R7 boot window masks PRAM");
      pop(16'h0080, 0, 1, 1, 24'h111111, 0, "");
      pop(16'h0080, 0, 1, 0, 24'h555555, 0, "");
      pop(16'h0080, 1, 0, 0, 0, 24'h111111, "R9 unqualified write ignored");
      pop(16'h02FF, 0, 1, 1, 24'h2F2F2F, 0, "");
      pop(16'h02FF, 1, 0, 0, 0, 24'h2F2F2F, "R8 last PRAM word");
      pop(16'h0300, 0, 1, 1, 24'h999999, 0, "");
      pop(16'h0300, 1, 0, 0, 0, 24'h0, "R8 beyond PRAM zero");

      // R5 clear, R7 normal fetch, R9 boot-mode write landed
      xop(16'h0200, 0, 1, 24'hFFFFFE, 0, "");
      mode_is(1'b0, "R5 mode cleared");
      xop(16'h0200, 1, 0, 0, 24'h0, "R5 mode read 0");
      pop(16'h0000, 1, 0, 0, 0, 24'h0A0A0A, "R9 write in boot window reached PRAM");
      xop(16'h0200, 0, 1, 24'h000001, 0, "");
      mode_is(1'b1, "R5 mode set by write");

      // R6 core_rst priority over a clearing write
      xop(16'h0200, 0, 1, 24'h0, 0, "");
      mode_is(1'b0, "R5 mode cleared again");
      @(negedge clk); clear_all();
      core_rst = 1; x_addr = 16'h0200; x_wr = 1; x_wdata = 24'h0;
      mode_is(1'b1, "R6 core_rst wins over write");
      pop(16'h0040, 1, 0, 0, 0, romw(24'h300000, 64), "R7 boot rom after core_rst");
      xop(16'h0200, 0, 1, 24'h0, 0, "");
      pop(16'h0000, 1, 0, 0, 0, 24'h0A0A0A, "R7 PRAM kept through core_rst");
      pop(16'h0080, 1, 0, 0, 0, 24'h111111, "R8 PRAM above window in normal mode");

      idle(3);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule